// File: doc/BRIEF.md
# Caption Data Line Inserter

This block produces the digital data envelope for the two caption lines of an NTSC frame. A host loads four 7-bit characters into a first-stage register bank: two characters for the first-field caption line and two for the second-field caption line. On each rising edge of vertical sync the whole bank is copied into a second stage, and the line generator reads only that second stage. A field therefore never shows a half-updated pair of characters.

When the frame timing reaches a configured pixel position on an enabled caption line, the block sends a fixed bit sequence. The sequence is a run-in of seven high/low periods, then the three start bits, then each character least significant bit first followed by its odd-parity bit. The output is a gate that marks the burst and a level select that picks the 50 IRE data level over blanking. A fractional accumulator sets the bit period, so the period does not have to be a whole number of clocks. An optional clear mode empties the first stage after every transfer, so a character is sent once and null follows unless the host writes again.

Top module: `cc_line_inserter`

## Requirements
- R1: After reset all eight character registers hold 0, `cc_gate` and `cc_hi` are 0, and an enabled caption line carries two null characters, each with parity bit 1.
- R2: `cc_mode` bit 0 enables line `LINE_A`, and bit 1 enables line `LINE_B`. The value 00 sends nothing, and 11 sends on both lines.
- R3: A burst has 33 slots. Slots 0 to 13 alternate 1,0 starting with 1. Slots 14, 15 and 16 are 0, 0 and 1.
- R4: Slots 17 to 23 carry character 1, bit 0 first, and slot 24 is its parity. Slots 25 to 31 carry character 2, and slot 32 is its parity. Each parity bit makes its 8-bit group hold an odd number of ones.
- R5: A host write reaches the line output only after the next rising edge of `vsync`. The second stage changes at no other time.
- R6: With `clr_en` = 1, every first-stage register is 0 after a `vsync` rising edge, once its old value has moved to the second stage. With `clr_en` = 0, the first stage keeps its value and the same characters are sent again on every field.
- R7: A write in the same cycle as a `vsync` rising edge lands in the first stage, even when clearing is on. It reaches the output only at the following edge.
- R8: `wr_sel` 0 and 1 select characters 1 and 2 of line `LINE_A`. `wr_sel` 2 and 3 select characters 1 and 2 of line `LINE_B`.
- R9: The burst starts when `pix_pos` equals `START_PIX` on an enabled line. In cycle c after that clock edge (c = 0 first), the slot shown is floor(c·BIT_INC/BIT_MOD). `cc_gate` stays high for exactly the cycles whose slot is at most 32.
- R10: Outside a burst, `cc_gate` and `cc_hi` are 0 on every line, enabled or not, and `cc_hi` is never 1 without `cc_gate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe for the first stage |
| wr_sel | input | 2 | Character select for the write |
| wr_data | input | 7 | Character value to write |
| vsync | input | 1 | Vertical sync; its rising edge moves the first stage into the second |
| line_num | input | LINE_W | Current frame line number |
| pix_pos | input | PIX_W | Current pixel position within the line |
| cc_mode | input | 2 | Per-line encode enable |
| clr_en | input | 1 | Clear the first stage after each transfer |
| cc_gate | output | 1 | High for the duration of the caption burst |
| cc_hi | output | 1 | Level select: 1 = data high (50 IRE), 0 = blanking |

## Verification
The bench builds the block with `START_PIX` = 5, `BIT_INC` = 2 and `BIT_MOD` = 5. This gives a bit period of 2.5 clocks, so the accumulator alternates between two- and three-cycle slots. A burst then lasts 83 cycles, and the bench can compare every cycle of it against the floor formula. Because the burst is this short, the bench can run all 128 codes on character 1 of one line and, through a bitwise-inverted pattern, on character 1 of the other, each behind its own field transfer. It can also step through every mode setting, the clear mode and a write that collides with the `vsync` edge.

// File: rtl/cc_line_inserter.sv
`timescale 1ns/1ps
module cc_line_inserter #(
  parameter int LINE_W    = 10,
  parameter int PIX_W     = 11,
  parameter int LINE_A    = 21,
  parameter int LINE_B    = 284,
  parameter int START_PIX = 260,
  parameter int BIT_INC   = 32,
  parameter int BIT_MOD   = 858
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [6:0]        wr_data,
  input  logic              vsync,
  input  logic [LINE_W-1:0] line_num,
  input  logic [PIX_W-1:0]  pix_pos,
  input  logic [1:0]        cc_mode,
  input  logic              clr_en,
  output logic              cc_gate,
  output logic              cc_hi
);
  localparam int ACC_W = $clog2(BIT_MOD + BIT_INC) + 1;
  localparam int LAST  = 32;
  localparam logic [ACC_W-1:0] INC_V = ACC_W'(BIT_INC);
  localparam logic [ACC_W-1:0] MOD_V = ACC_W'(BIT_MOD);

  logic [3:0][6:0] s1, s2;
  logic            vs_q;
  logic            active, sel_b;
  logic [5:0]      slot;
  logic [ACC_W-1:0] acc;

  wire vs_rise = vsync & ~vs_q;
  wire hit_a   = (line_num == LINE_W'(LINE_A)) & cc_mode[0];
  wire hit_b   = (line_num == LINE_W'(LINE_B)) & cc_mode[1];
  wire start   = ~active & (pix_pos == PIX_W'(START_PIX)) & (hit_a | hit_b);
  wire [ACC_W-1:0] acc_sum = acc + INC_V;
  wire wrap    = acc_sum >= MOD_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      vs_q <= 1'b0;
    end else begin
      vs_q <= vsync;
      if (vs_rise) begin
        s2 <= s1;
        if (clr_en) s1 <= '0;
      end
      if (wr_en) s1[wr_sel] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sel_b  <= 1'b0;
      slot   <= '0;
      acc    <= '0;
    end else if (start) begin
      active <= 1'b1;
      sel_b  <= ~hit_a;
      slot   <= '0;
      acc    <= '0;
    end else if (active) begin
      acc <= wrap ? acc_sum - MOD_V : acc_sum;
      if (wrap) begin
        if (slot == 6'(LAST)) active <= 1'b0;
        else                  slot   <= slot + 6'd1;
      end
    end
  end

  wire [6:0]  ch1   = sel_b ? s2[2] : s2[0];
  wire [6:0]  ch2   = sel_b ? s2[3] : s2[1];
  wire [32:0] frame = {~^ch2, ch2, ~^ch1, ch1, 3'b100, 14'h1555};

  assign cc_gate = active;
  assign cc_hi   = active & frame[slot];
endmodule

module cc_line_inserter_chk #(
  parameter int LINE_W    = 10,
  parameter int PIX_W     = 11,
  parameter int LINE_A    = 21,
  parameter int LINE_B    = 284,
  parameter int START_PIX = 260
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              vsync,
  input logic              vs_q,
  input logic              clr_en,
  input logic [1:0]        cc_mode,
  input logic [LINE_W-1:0] line_num,
  input logic [PIX_W-1:0]  pix_pos,
  input logic [3:0][6:0]   s1,
  input logic [3:0][6:0]   s2,
  input logic              cc_gate,
  input logic              cc_hi
);
  // R10
  hi_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cc_hi |-> cc_gate);
  // R3
  runin_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_gate) |-> cc_hi);
  // R2
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_gate) |-> (($past(line_num) == LINE_W'(LINE_A) && $past(cc_mode[0])) ||
                        ($past(line_num) == LINE_W'(LINE_B) && $past(cc_mode[1]))));
  // R9
  start_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_gate) |-> $past(pix_pos) == PIX_W'(START_PIX));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vsync && !vs_q) |=> $stable(s2));
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !vs_q && clr_en && !wr_en) |=> (s1 == '0));
endmodule

bind cc_line_inserter cc_line_inserter_chk #(
  .LINE_W(LINE_W), .PIX_W(PIX_W), .LINE_A(LINE_A), .LINE_B(LINE_B), .START_PIX(START_PIX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .vsync(vsync), .vs_q(vs_q), .clr_en(clr_en),
  .cc_mode(cc_mode), .line_num(line_num), .pix_pos(pix_pos), .s1(s1), .s2(s2),
  .cc_gate(cc_gate), .cc_hi(cc_hi)
);

// File: tb/sim_cc_line_inserter.sv
`timescale 1ns/1ps
module sim_cc_line_inserter;
  localparam int START = 5;
  localparam int INC   = 2;
  localparam int MOD   = 5;

  logic clk = 0, rst_n = 0, wr_en = 0, vsync = 0, clr_en = 0;
  logic [1:0] wr_sel = 0, cc_mode = 0;
  logic [6:0] wr_data = 0;
  logic [9:0] line_num = 0;
  logic [10:0] pix_pos = 0;
  logic cc_gate, cc_hi;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cc_line_inserter #(.START_PIX(START), .BIT_INC(INC), .BIT_MOD(MOD)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .vsync(vsync), .line_num(line_num), .pix_pos(pix_pos), .cc_mode(cc_mode),
    .clr_en(clr_en), .cc_gate(cc_gate), .cc_hi(cc_hi));

  function automatic logic exp_slot(int s, logic [6:0] a, logic [6:0] b);
    if (s < 14)  return (s % 2) == 0;
    if (s < 16)  return 1'b0;
    if (s == 16) return 1'b1;
    if (s < 24)  return a[s-17];
    if (s == 24) return ~^a;
    if (s < 32)  return b[s-25];
    return ~^b;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [6:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic vs_pulse();
    @(negedge clk); vsync = 1;
    @(negedge clk); vsync = 0;
  endtask

  // Sweeps one line; every cycle of gate and level compared to the R9 formula
  task automatic run_line(input int ln, input bit en, input logic [6:0] a,
                          input logic [6:0] b, input string tag);
    bit bad = 0;
    checks++;
    @(negedge clk);
    line_num = ln[9:0];
    pix_pos = 0;
    for (int k = 0; k < START + 96; k++) begin
      @(negedge clk);
      begin
        int c = k - START - 1;
        logic eg, eh;
        eg = en && c >= 0 && (c * INC) / MOD <= 32;
        eh = eg ? exp_slot((c * INC) / MOD, a, b) : 1'b0;
        if ((cc_gate !== eg || cc_hi !== eh) && !bad) begin
          bad = 1;
          $display("FAIL %s line %0d cycle %0d gate,hi=%b%b expected %b%b",
                   tag, ln, c, cc_gate, cc_hi, eg, eh);
        end
      end
      pix_pos = k[10:0];
    end
    pix_pos = 0;
    if (bad) errors++;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (cc_gate !== 0 || cc_hi !== 0) begin
      errors++;
      $display("FAIL R1 reset outputs %b%b expected 00", cc_gate, cc_hi);
    end
    rst_n = 1;
    cc_mode = 2'b11;
    run_line(21, 1, 7'h00, 7'h00, "R1 R3 R4");
    run_line(284, 1, 7'h00, 7'h00, "R1");
    wr(0, 7'h41); wr(1, 7'h7F);
    run_line(21, 1, 7'h00, 7'h00, "R5 before vsync");
    vs_pulse();
    run_line(21, 1, 7'h41, 7'h7F, "R5 R8");
    run_line(284, 1, 7'h00, 7'h00, "R8");
    wr(2, 7'h13); wr(3, 7'h64); vs_pulse();
    run_line(284, 1, 7'h13, 7'h64, "R8");
    run_line(21, 1, 7'h41, 7'h7F, "R8");
    cc_mode = 2'b01;
    run_line(284, 0, 0, 0, "R2 mode01");
    run_line(21, 1, 7'h41, 7'h7F, "R2 mode01");
    cc_mode = 2'b10;
    run_line(21, 0, 0, 0, "R2 mode10");
    run_line(284, 1, 7'h13, 7'h64, "R2 mode10");
    cc_mode = 2'b00;
    run_line(21, 0, 0, 0, "R2 mode00");
    run_line(284, 0, 0, 0, "R2 mode00");
    cc_mode = 2'b11;
    run_line(22, 0, 0, 0, "R10");
    run_line(20, 0, 0, 0, "R10");
    vs_pulse();
    run_line(21, 1, 7'h41, 7'h7F, "R6 keep");
    // R7 write on the vsync edge cycle
    @(negedge clk); vsync = 1; wr_en = 1; wr_sel = 1; wr_data = 7'h2A;
    @(negedge clk); vsync = 0; wr_en = 0;
    run_line(21, 1, 7'h41, 7'h7F, "R7 same edge");
    vs_pulse();
    run_line(21, 1, 7'h41, 7'h2A, "R7 next edge");
    clr_en = 1;
    wr(0, 7'h55); vs_pulse();
    run_line(21, 1, 7'h55, 7'h2A, "R6 clear");
    vs_pulse();
    run_line(21, 1, 7'h00, 7'h00, "R6 cleared");
    run_line(284, 1, 7'h00, 7'h00, "R6 cleared");
    clr_en = 0;
    for (int v = 0; v < 128; v++) begin
      logic [6:0] x = v[6:0];
      wr(0, x); wr(1, x ^ 7'h5A); wr(2, ~x); wr(3, x + 7'd1);
      vs_pulse();
      run_line(21, 1, x, x ^ 7'h5A, "R4 R9 sweep");
      run_line(284, 1, ~x, x + 7'd1, "R4 R9 sweep");
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule